// File: doc/BRIEF.md
# Byte-Lane Memory Slave With Access Checks

This block is a synchronous, word-wide RAM that sits on a 32-bit processor-style memory bus. Every clock cycle in which `memReq` is high carries one transfer: a byte address, a two-bit size code, a write strobe, a flag that marks the cycle as the next beat of a sequential burst, a flag that tells an instruction fetch from a data transfer, and a privilege flag. The slave drops the low address bits that carry no meaning for the transfer size, and turns size and address into four byte-lane enables. A byte or halfword store therefore changes only its own lanes.

On a sequential cycle the slave ignores the bus address. It uses its own burst pointer instead, which it loads on the first beat and then steps by the transfer size. Before any access reaches the storage array, it passes a set of checks: a reserved size, a malformed burst, a write marked as a fetch, or a user-mode data access into the protected upper region. An access that fails any check is blocked and reported on `abortOut`. Read data and the abort flag appear one cycle after the request.

Top module: `memslv_top`

## Requirements
- R1: Size code 00 is a byte transfer. Address bits [1:0] pick the lane little-endian (00 = bits 7:0 … 11 = bits 31:24). A byte write stores only that lane of `wdata` and leaves the other three bytes unchanged.
- R2: Size code 01 is a halfword transfer. Address bit 1 picks the lower (bits 15:0) or upper (bits 31:16) halfword lanes, and address bit 0 is ignored.
- R3: Size code 10 is a word transfer. It writes all four lanes, and address bits [1:0] are ignored.
- R4: A legal read returns, in the cycle after the request, the stored bytes on the selected lanes and zero on the other lanes. Redundant low address bits, including those on fetches, do not change the result. The word index is address bits [9:2] for the default depth of 256, and higher bits are ignored.
- R5: Size code 11 is reserved. Such an access aborts and writes nothing.
- R6: On a legal non-sequential access, the burst pointer is loaded with the aligned address plus 2 (halfword) or 4 (word). On a legal sequential cycle, the pointer is used as the address, the bus address is ignored, and the pointer advances by the same step.
- R7: A sequential cycle aborts when no burst is open or when its size differs from the size of the burst. A burst closes on any abort and on any idle cycle.
- R8: A sequential cycle with size code 00 (a byte burst) aborts.
- R9: A write with `isData` = 0 (a fetch) aborts.
- R10: A data access (`isData` = 1) with `privMode` = 0 aborts when its word index is 192 or higher. Fetches and privileged accesses to that region are allowed.
- R11: An aborted access leaves memory unchanged, gives `abortOut` = 1 and `rdata` = 0 in the next cycle, and lasts one cycle. Idle cycles and write cycles give `rdata` = 0 with no abort.
- R12: During and right after reset, `rdata` is 0, `abortOut` is 0, and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memReq | input | 1 | A transfer is present this cycle |
| seqCycle | input | 1 | Transfer is the next beat of a sequential burst |
| addr | input | 32 | Byte address |
| sizeCode | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| writeEn | input | 1 | 1 write, 0 read |
| isData | input | 1 | 0 opcode fetch, 1 data transfer |
| privMode | input | 1 | 1 privileged, 0 user |
| wdata | input | 32 | Write data, lane-aligned |
| rdata | output | 32 | Read data, one cycle after the request |
| abortOut | output | 1 | Access failed a check, one cycle after the request |

## Verification
After the whole array is filled with word writes, byte, halfword and word stores land on every lane position. Each store is read back at full width, which exposes a wrong lane decode or an extra lane being written. Reads and fetches repeat with the redundant low bits set to 1 and with junk in the high address bits, to show those bits are ignored. Directed bursts send a junk bus address on every sequential beat, which separates use of the burst pointer from use of the bus address. Each illegal case is run on its own, next to the legal neighbour that differs in only one input. Long random runs then mix sizes, bursts, privilege and region against a bench model.

// File: rtl/memslv_pkg.sv
package memslv_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } xferSize_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic       wrEn;
    logic       rdEn;
    logic       abort;
    logic [3:0] lanes;
  } dpStrobes_t;

  function automatic logic [3:0] laneMask(input xferSize_e sz, input logic [1:0] lo);
    logic [3:0] m;
    case (sz)
      SZ_BYTE: m = 4'b0001 << lo;
      SZ_HALF: m = lo[1] ? 4'b1100 : 4'b0011;
      SZ_WORD: m = 4'b1111;
      default: m = 4'b0000;
    endcase
    return m;
  endfunction

  function automatic logic [31:0] stepFor(input xferSize_e sz);
    logic [31:0] s;
    case (sz)
      SZ_HALF: s = 32'd2;
      SZ_WORD: s = 32'd4;
      default: s = 32'd1;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/memslv_ctrl.sv
module memslv_ctrl
  import memslv_pkg::*;
#(
  parameter int DEPTH_WORDS = 256,
  parameter int PROT_BASE   = 192,
  localparam int IDX_W      = $clog2(DEPTH_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             memReq,
  input  logic             seqCycle,
  input  logic [31:0]      addr,
  input  logic [1:0]       sizeCode,
  input  logic             writeEn,
  input  logic             isData,
  input  logic             privMode,
  output dpStrobes_t       strobes,
  output logic [IDX_W-1:0] wordIdx
);

  xferSize_e   sz;
  xferSize_e   burstSize;
  logic        burstOpen;
  logic [31:0] burstAddr;
  logic [31:0] rawAddr;
  logic [31:0] alignAddr;
  logic        errSize, errSeq, errOpc, errProt, anyErr, accessOk;

  assign sz = xferSize_e'(sizeCode);

  // sequential beats follow the internal pointer, not the bus
  assign rawAddr = seqCycle ? burstAddr : addr;

  always_comb begin
    case (sz)
      SZ_HALF: alignAddr = {rawAddr[31:1], 1'b0};
      SZ_WORD: alignAddr = {rawAddr[31:2], 2'b00};
      default: alignAddr = rawAddr;
    endcase
  end

  assign wordIdx = alignAddr[IDX_W+1:2];

  always_comb begin
    errSize  = (sz == SZ_RSVD);
    errSeq   = seqCycle && (!burstOpen || (sz != burstSize) || (sz == SZ_BYTE));
    errOpc   = writeEn && !isData;
    errProt  = !privMode && isData &&
               ({{(32-IDX_W){1'b0}}, wordIdx} >= 32'(PROT_BASE));
    anyErr   = errSize | errSeq | errOpc | errProt;
    accessOk = memReq && !anyErr;
  end

  always_comb begin
    strobes.wrEn  = accessOk && writeEn;
    strobes.rdEn  = accessOk && !writeEn;
    strobes.abort = memReq && anyErr;
    strobes.lanes = laneMask(sz, alignAddr[1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstOpen <= 1'b0;
      burstSize <= SZ_BYTE;
      burstAddr <= 32'd0;
    end else if (accessOk) begin
      burstOpen <= 1'b1;
      burstSize <= sz;
      burstAddr <= alignAddr + stepFor(sz);
    end else begin
      burstOpen <= 1'b0;
    end
  end

endmodule

// File: rtl/memslv_dp.sv
module memslv_dp
  import memslv_pkg::*;
#(
  parameter int DEPTH_WORDS = 256,
  localparam int IDX_W      = $clog2(DEPTH_WORDS),
  localparam int LANES      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic [IDX_W-1:0] wordIdx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             abortOut
);

  logic [31:0] memWord;
  logic [31:0] laneBits;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] laneMem [DEPTH_WORDS];
      always_ff @(posedge clk) begin
        if (strobes.wrEn && strobes.lanes[g])
          laneMem[wordIdx] <= wdata[8*g +: 8];
      end
      assign memWord[8*g +: 8]  = laneMem[wordIdx];
      assign laneBits[8*g +: 8] = {8{strobes.lanes[g]}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata    <= 32'd0;
      abortOut <= 1'b0;
    end else begin
      rdata    <= strobes.rdEn ? (memWord & laneBits) : 32'd0;
      abortOut <= strobes.abort;
    end
  end

endmodule

// File: rtl/memslv_top.sv
module memslv_top
  import memslv_pkg::*;
#(
  parameter int DEPTH_WORDS = 256,
  parameter int PROT_BASE   = 192,
  localparam int IDX_W      = $clog2(DEPTH_WORDS)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        memReq,
  input  logic        seqCycle,
  input  logic [31:0] addr,
  input  logic [1:0]  sizeCode,
  input  logic        writeEn,
  input  logic        isData,
  input  logic        privMode,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        abortOut
);

  dpStrobes_t       strobes;
  logic [IDX_W-1:0] wordIdx;

  memslv_ctrl #(.DEPTH_WORDS(DEPTH_WORDS), .PROT_BASE(PROT_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .memReq(memReq), .seqCycle(seqCycle),
    .addr(addr), .sizeCode(sizeCode), .writeEn(writeEn), .isData(isData),
    .privMode(privMode), .strobes(strobes), .wordIdx(wordIdx)
  );

  memslv_dp #(.DEPTH_WORDS(DEPTH_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wordIdx(wordIdx),
    .wdata(wdata), .rdata(rdata), .abortOut(abortOut)
  );

endmodule

// File: rtl/memslv_check.sv
module memslv_check #(
  parameter int DEPTH_WORDS = 256,
  parameter int PROT_BASE   = 192,
  localparam int IDX_W      = $clog2(DEPTH_WORDS)
) (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        seqCycle,
  input logic [31:0] addr,
  input logic [1:0]  sizeCode,
  input logic        writeEn,
  input logic        isData,
  input logic        privMode,
  input logic [31:0] rdata,
  input logic        abortOut
);

  logic userProtHit;
  assign userProtHit = !privMode && isData &&
                       ({{(32-IDX_W){1'b0}}, addr[IDX_W+1:2]} >= 32'(PROT_BASE));

  AST_RSVD_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    memReq && sizeCode == 2'b11 |=> abortOut);                         // R5
  AST_BYTE_BURST_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    memReq && seqCycle && sizeCode == 2'b00 |=> abortOut);             // R8
  AST_FETCH_WRITE_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    memReq && writeEn && !isData |=> abortOut);                        // R9
  AST_USER_PROT_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !seqCycle && userProtHit |=> abortOut);                  // R10
  AST_ABORT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    abortOut |-> rdata == 32'd0);                                      // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !memReq |=> !abortOut && rdata == 32'd0);                          // R11
  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    memReq && writeEn |=> rdata == 32'd0);                             // R11
  AST_SEQ_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !memReq ##1 (memReq && seqCycle) |=> abortOut);                    // R7

endmodule

bind memslv_top memslv_check #(.DEPTH_WORDS(DEPTH_WORDS), .PROT_BASE(PROT_BASE)) u_check (
  .clk(clk), .rstN(rstN), .memReq(memReq), .seqCycle(seqCycle), .addr(addr),
  .sizeCode(sizeCode), .writeEn(writeEn), .isData(isData), .privMode(privMode),
  .rdata(rdata), .abortOut(abortOut)
);

// File: tb/memslv_top_test.sv
module memslv_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;
  localparam int PROT       = 192;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memReq = 1'b0, seqCycle = 1'b0, writeEn = 1'b0, isData = 1'b1, privMode = 1'b1;
  logic [31:0] addr = '0, wdata = '0;
  logic [1:0]  sizeCode = 2'b10;
  logic [31:0] rdata;
  logic        abortOut;

  int checks = 0;
  int failures = 0;

  logic [31:0] model [DEPTH];
  bit          bOpen = 0;
  logic [1:0]  bSize = 2'b00;
  logic [31:0] bAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memslv_top uut (
    .clk(clk), .rstN(rstN), .memReq(memReq), .seqCycle(seqCycle), .addr(addr),
    .sizeCode(sizeCode), .writeEn(writeEn), .isData(isData), .privMode(privMode),
    .wdata(wdata), .rdata(rdata), .abortOut(abortOut)
  );

  function automatic logic [31:0] expandLanes(input logic [1:0] sz, input logic [1:0] lo);
    logic [31:0] m;
    case (sz)
      2'b00: m = 32'hFF << (8 * lo);
      2'b01: m = lo[1] ? 32'hFFFF0000 : 32'h0000FFFF;
      2'b10: m = 32'hFFFFFFFF;
      default: m = 32'h0;
    endcase
    return m;
  endfunction

  function automatic logic [31:0] alignTo(input logic [1:0] sz, input logic [31:0] a);
    if (sz == 2'b01) return a & ~32'd1;
    if (sz == 2'b10) return a & ~32'd3;
    return a;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one bus cycle, update the model, compare in the following cycle
  task automatic doStep(input string tag, input bit req, input bit seq, input logic [31:0] a,
                        input logic [1:0] sz, input bit we, input bit dat, input bit pr,
                        input logic [31:0] wd);
    logic [31:0] eff, m, expData;
    bit err;
    memReq = req; seqCycle = seq; addr = a; sizeCode = sz;
    writeEn = we; isData = dat; privMode = pr; wdata = wd;
    eff = alignTo(sz, seq ? bAddr : a);
    err = (sz == 2'b11) || (seq && (!bOpen || sz != bSize || sz == 2'b00))
       || (we && !dat) || (!pr && dat && eff[9:2] >= PROT);
    m = expandLanes(sz, eff[1:0]);
    expData = 32'd0;
    if (req && !err) begin
      if (we) model[eff[9:2]] = (model[eff[9:2]] & ~m) | (wd & m);
      else expData = model[eff[9:2]] & m;
      bOpen = 1; bSize = sz;
      bAddr = eff + ((sz == 2'b10) ? 32'd4 : (sz == 2'b01) ? 32'd2 : 32'd1);
    end else begin
      bOpen = 0;
    end
    @(negedge clk);
    check({tag, " rdata"}, rdata, expData);
    check({tag, " abort"}, {31'd0, abortOut}, {31'd0, req && err});
  endtask

  task automatic idle();
    doStep("R11 idle", 0, 0, 32'h0, 2'b10, 0, 1, 1, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R12 reset rdata", rdata, 32'd0);
    check("R12 reset abort", {31'd0, abortOut}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R12: no burst open after reset
    doStep("R12 seq after reset", 1, 1, 32'h0, 2'b10, 0, 1, 1, 32'h0);

    // R3: fill every word, redundant low bits set
    for (int i = 0; i < DEPTH; i++)
      doStep("R3 fill", 1, 0, (i << 2) | 32'd3, 2'b10, 1, 1, 1, $urandom());

    // R1: each lane
    for (int l = 0; l < 4; l++) begin
      doStep("R1 byte write", 1, 0, 32'h40 + l, 2'b00, 1, 1, 1, 32'hA1B2C3D4 + l);
      doStep("R1 readback", 1, 0, 32'h40, 2'b10, 0, 1, 1, 32'h0);
      doStep("R1 byte read", 1, 0, 32'h40 + l, 2'b00, 0, 1, 1, 32'h0);
    end
    // R2: halfwords with bit0 set
    doStep("R2 half low", 1, 0, 32'h51, 2'b01, 1, 1, 1, 32'h11112222);
    doStep("R2 half high", 1, 0, 32'h53, 2'b01, 1, 1, 1, 32'h33334444);
    doStep("R2 readback", 1, 0, 32'h50, 2'b10, 0, 1, 1, 32'h0);
    doStep("R2 half read", 1, 0, 32'h53, 2'b01, 0, 1, 1, 32'h0);
    // R4: fetch with redundant bits and high junk
    doStep("R4 fetch", 1, 0, 32'hFFFF0053, 2'b10, 0, 0, 0, 32'h0);
    doStep("R4 fetch half", 1, 0, 32'h7A000051, 2'b01, 0, 0, 1, 32'h0);
    // R5
    doStep("R5 reserved write", 1, 0, 32'h50, 2'b11, 1, 1, 1, 32'hDEADBEEF);
    doStep("R5 readback", 1, 0, 32'h50, 2'b10, 0, 1, 1, 32'h0);
    // R6: word burst ignoring bus address
    doStep("R6 burst start", 1, 0, 32'h12, 2'b10, 0, 1, 1, 32'h0);
    doStep("R6 word beat", 1, 1, 32'hDEAD0000, 2'b10, 0, 1, 1, 32'h0);
    doStep("R6 word beat", 1, 1, 32'hBEEF0004, 2'b10, 1, 1, 1, 32'hCAFEF00D);
    doStep("R6 readback", 1, 0, 32'h18, 2'b10, 0, 1, 1, 32'h0);
    // R6: halfword burst crossing a word
    doStep("R6 half start", 1, 0, 32'h62, 2'b01, 1, 1, 1, 32'h5A5A5A5A);
    doStep("R6 half beat", 1, 1, 32'h0, 2'b01, 1, 1, 1, 32'h6B6B6B6B);
    doStep("R6 half beat", 1, 1, 32'h0, 2'b01, 0, 1, 1, 32'h0);
    doStep("R6 readback", 1, 0, 32'h64, 2'b10, 0, 1, 1, 32'h0);
    // R7: size change, then dead burst
    doStep("R7 start", 1, 0, 32'h70, 2'b10, 0, 1, 1, 32'h0);
    doStep("R7 size change", 1, 1, 32'h0, 2'b01, 1, 1, 1, 32'hFFFFFFFF);
    doStep("R7 after abort", 1, 1, 32'h0, 2'b10, 0, 1, 1, 32'h0);
    doStep("R7 start2", 1, 0, 32'h70, 2'b10, 0, 1, 1, 32'h0);
    idle();
    doStep("R7 seq after idle", 1, 1, 32'h0, 2'b10, 0, 1, 1, 32'h0);
    // R8
    doStep("R8 byte start", 1, 0, 32'h80, 2'b00, 0, 1, 1, 32'h0);
    doStep("R8 byte burst", 1, 1, 32'h81, 2'b00, 1, 1, 1, 32'h99999999);
    doStep("R8 readback", 1, 0, 32'h80, 2'b10, 0, 1, 1, 32'h0);
    // R9
    doStep("R9 fetch write", 1, 0, 32'h90, 2'b10, 1, 0, 1, 32'h12345678);
    doStep("R9 readback", 1, 0, 32'h90, 2'b10, 0, 1, 1, 32'h0);
    // R10
    doStep("R10 user data write", 1, 0, PROT * 4, 2'b10, 1, 1, 0, 32'h0BADF00D);
    doStep("R10 user data read", 1, 0, 32'h3FC, 2'b10, 0, 1, 0, 32'h0);
    doStep("R10 user fetch", 1, 0, PROT * 4, 2'b10, 0, 0, 0, 32'h0);
    doStep("R10 user below", 1, 0, PROT * 4 - 4, 2'b10, 0, 1, 0, 32'h0);
    doStep("R10 priv write", 1, 0, PROT * 4, 2'b10, 1, 1, 1, 32'h600DF00D);
    doStep("R10 readback", 1, 0, PROT * 4, 2'b10, 0, 1, 1, 32'h0);
    // R11: one-cycle abort
    doStep("R11 abort", 1, 0, 32'h0, 2'b11, 0, 1, 1, 32'h0);
    doStep("R11 abort clears", 1, 0, 32'h0, 2'b10, 0, 1, 1, 32'h0);

    // constrained random mix
    for (int n = 0; n < 6000; n++) begin
      bit req, seq, we, dat, pr;
      logic [1:0] sz;
      logic [31:0] a;
      req = ($urandom_range(9) != 0);
      seq = bOpen && ($urandom_range(9) < 6);
      case ($urandom_range(9))
        0, 1:    sz = 2'b00;
        2, 3, 4: sz = 2'b01;
        9:       sz = 2'b11;
        default: sz = 2'b10;
      endcase
      if (seq && $urandom_range(4) != 0) sz = bSize;
      we  = $urandom_range(1);
      dat = ($urandom_range(7) != 0);
      pr  = ($urandom_range(4) < 3);
      a   = $urandom();
      doStep(we ? "R1 R2 R3 rand write" : "R4 R6 rand read", req, seq, a, sz, we, dat, pr, $urandom());
    end
    // final sweep: compare every word
    for (int i = 0; i < DEPTH; i++)
      doStep("R4 sweep", 1, 0, i << 2, 2'b10, 0, 1, 1, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule